// File: doc/BRIEF.md
# LCD Timebase with Blink Generator

This block derives the timing references of a segment display controller from one slow input clock. A power-of-two prescaler emits a single-cycle tick every 2^N input cycles. A second stage counts those ticks and closes a frame after a ratio chosen between 16 and 31, giving the frame rate. A third stage counts frames and toggles a blink phase. The blink phase, combined with a two-bit coverage mode, tells the segment driver which pixels to blank at this moment.

Every output is an enable or a level in the input clock domain; no derived clock is generated. Each divider latches its setting at its own terminal count, so a new setting never shortens the period in progress. A start-of-frame strobe sets a sticky flag. Software clears the flag with a strobe, and an enable bit masks the flag onto the interrupt pin. All pins are plain control and status pins; the block has no data stream and so no valid/ready handshake.

Top module: `lcdt_timebase`

## Requirements
- R1: `psc_tick` is high for one input cycle out of every 2^`cfg_psc` cycles. With `cfg_psc`=0 it is high on every cycle.
- R2: `frame_start` is high for one cycle once every (16 + `cfg_ratio`) `psc_tick` pulses, and only in a cycle where `psc_tick` is high.
- R3: `blink_phase` inverts once every 2^(`cfg_blink_rate`+2) frames, so one full on/off cycle spans 2^(`cfg_blink_rate`+3) frames.
- R4: `blink_sel` is all zero while `blink_phase` is 0 or `cfg_blink_mode` is 0. While `blink_phase` is 1, mode 1 sets bit 0 (single pixel), mode 2 sets bit 1 (segment 0 on all commons) and mode 3 sets bit 2 (every pixel).
- R5: A `frame_start` cycle sets a sticky flag, visible from the next cycle. A one-cycle `sof_irq_clr` pulse clears the flag. If both fall in the same cycle, the set wins.
- R6: `sof_irq` shows the flag only while `sof_irq_en` is 1, and is 0 otherwise.
- R7: A change to `cfg_psc`, `cfg_ratio` or `cfg_blink_rate` takes effect only after the affected counter's next terminal count. The period in progress completes at its old length.
- R8: After reset, `blink_phase`, `blink_sel`, `frame_start` and `sof_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow display input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_psc | input | 4 | Prescaler exponent N, divide by 2^N |
| cfg_ratio | input | 4 | Frame ratio offset, divide by 16 + value |
| cfg_blink_rate | input | 3 | Blink rate exponent |
| cfg_blink_mode | input | 2 | Blink coverage mode |
| sof_irq_en | input | 1 | Interrupt enable |
| sof_irq_clr | input | 1 | Flag clear strobe |
| psc_tick | output | 1 | Prescaled tick enable |
| frame_start | output | 1 | Frame tick / start-of-frame strobe |
| blink_phase | output | 1 | Current blink phase |
| blink_sel | output | 3 | One-hot blank selection for this moment |
| sof_irq | output | 1 | Masked start-of-frame interrupt |

## Verification
A flag clear and a start-of-frame set can land in the same cycle. The bench waits for a sampled `frame_start` and raises `sof_irq_clr` during that very cycle. It then expects `sof_irq` to read 1 after the edge, because the set must win. A later clear with no frame start must bring the pin back to 0. A setting change that lands just after a terminal count is a second interaction: the bench then judges that one complete interval keeps the old length.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int PSC_W      = 4;
  localparam int RATIO_W    = 4;
  localparam int RATIO_BASE = 16;
  localparam int BRATE_W    = 3;
  localparam int BRATE_LOG0 = 3;
  localparam int BMODE_W    = 2;

  typedef enum logic [BMODE_W-1:0] {
    BLK_OFF    = 2'd0,
    BLK_ONE    = 2'd1,
    BLK_COLUMN = 2'd2,
    BLK_ALL    = 2'd3
  } blink_mode_e;
endpackage

// File: rtl/lcdt_pow2_prescaler.sv
module lcdt_pow2_prescaler #(
  parameter int PSC_W = lcdt_pkg::PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_exp,
  output logic             tick
);
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] exp_q;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   last_full;
  logic [CNT_W-1:0] last;

  always_comb begin
    span      = {{CNT_W{1'b0}}, 1'b1} << exp_q;
    last_full = span - 1'b1;
    last      = last_full[CNT_W-1:0];
  end

  assign tick = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      exp_q <= cfg_exp;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  p_exp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(exp_q));
endmodule

// File: rtl/lcdt_frame_div.sv
module lcdt_frame_div #(
  parameter int RATIO_W    = lcdt_pkg::RATIO_W,
  parameter int RATIO_BASE = lcdt_pkg::RATIO_BASE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [RATIO_W-1:0] cfg_ratio,
  output logic               frame_tick
);
  localparam int CNT_W = $clog2(RATIO_BASE + (1 << RATIO_W));

  logic [CNT_W-1:0]   cnt_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   last;

  assign last       = CNT_W'(RATIO_BASE - 1) + CNT_W'(ratio_q);
  assign frame_tick = step && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else if (frame_tick) begin
      cnt_q   <= '0;
      ratio_q <= cfg_ratio;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(ratio_q));
endmodule

// File: rtl/lcdt_blink.sv
module lcdt_blink #(
  parameter int BRATE_W    = lcdt_pkg::BRATE_W,
  parameter int BRATE_LOG0 = lcdt_pkg::BRATE_LOG0,
  parameter int BMODE_W    = lcdt_pkg::BMODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_tick,
  input  logic [BRATE_W-1:0]         cfg_rate,
  input  logic [BMODE_W-1:0]         cfg_mode,
  output logic                       phase,
  output logic [(1<<BMODE_W)-2:0]    sel
);
  localparam int NSEL  = (1 << BMODE_W) - 1;
  localparam int CNT_W = (1 << BRATE_W) - 1 + BRATE_LOG0 - 1;

  logic [CNT_W-1:0]   cnt_q;
  logic [BRATE_W-1:0] rate_q;
  logic [CNT_W:0]     span;
  logic [CNT_W:0]     last_full;
  logic [CNT_W-1:0]   last;
  logic               flip;

  always_comb begin
    span      = {{CNT_W{1'b0}}, 1'b1} << (CNT_W'(rate_q) + CNT_W'(BRATE_LOG0 - 1));
    last_full = span - 1'b1;
    last      = last_full[CNT_W-1:0];
  end

  assign flip = frame_tick && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
      phase  <= 1'b0;
    end else if (flip) begin
      cnt_q  <= '0;
      rate_q <= cfg_rate;
      phase  <= ~phase;
    end else if (frame_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign sel[g] = phase && (cfg_mode == BMODE_W'(g + 1));
  end

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(phase));
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  p_rate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(rate_q));
endmodule

// File: rtl/lcdt_timebase.sv
module lcdt_timebase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfg_psc,
  input  logic [3:0] cfg_ratio,
  input  logic [2:0] cfg_blink_rate,
  input  logic [1:0] cfg_blink_mode,
  input  logic       sof_irq_en,
  input  logic       sof_irq_clr,
  output logic       psc_tick,
  output logic       frame_start,
  output logic       blink_phase,
  output logic [2:0] blink_sel,
  output logic       sof_irq
);
  import lcdt_pkg::*;

  logic sof_flag_q;

  lcdt_pow2_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_exp (cfg_psc),
    .tick    (psc_tick)
  );

  lcdt_frame_div #(.RATIO_W(RATIO_W), .RATIO_BASE(RATIO_BASE)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (psc_tick),
    .cfg_ratio  (cfg_ratio),
    .frame_tick (frame_start)
  );

  lcdt_blink #(.BRATE_W(BRATE_W), .BRATE_LOG0(BRATE_LOG0), .BMODE_W(BMODE_W)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_start),
    .cfg_rate   (cfg_blink_rate),
    .cfg_mode   (cfg_blink_mode),
    .phase      (blink_phase),
    .sel        (blink_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sof_flag_q <= 1'b0;
    else if (frame_start) sof_flag_q <= 1'b1;
    else if (sof_irq_clr) sof_flag_q <= 1'b0;
  end

  assign sof_irq = sof_flag_q & sof_irq_en;

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sof_flag_q);
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_irq_clr && !frame_start) |=> !sof_flag_q);
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |-> (sof_irq_en && sof_flag_q));
  p_frame_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> psc_tick);
endmodule

// File: tb/lcdt_timebase_tb.sv
module lcdt_timebase_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NV = 6;
  localparam int T_PSC  [NV] = '{0, 1, 2, 3, 0, 10};
  localparam int T_RAT  [NV] = '{0, 0, 5, 15, 15, 0};
  localparam int T_PPER [NV] = '{1, 2, 4, 8, 1, 1024};
  localparam int T_FPER [NV] = '{16, 32, 84, 248, 31, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_psc = '0;
  logic [3:0] cfg_ratio = '0;
  logic [2:0] cfg_blink_rate = '0;
  logic [1:0] cfg_blink_mode = '0;
  logic       sof_irq_en = 1'b0;
  logic       sof_irq_clr = 1'b0;
  logic       psc_tick, frame_start, blink_phase, sof_irq;
  logic [2:0] blink_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lcdt_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_psc(cfg_psc), .cfg_ratio(cfg_ratio),
    .cfg_blink_rate(cfg_blink_rate), .cfg_blink_mode(cfg_blink_mode),
    .sof_irq_en(sof_irq_en), .sof_irq_clr(sof_irq_clr),
    .psc_tick(psc_tick), .frame_start(frame_start), .blink_phase(blink_phase),
    .blink_sel(blink_sel), .sof_irq(sof_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic ev(input int kind, input logic prev);
    if (kind == 0) return psc_tick;
    if (kind == 1) return frame_start;
    return blink_phase != prev;
  endfunction

  task automatic wait_ev(input int kind);
    logic prev = blink_phase;
    do @(negedge clk); while (!ev(kind, prev));
  endtask

  task automatic measure(input int kind, output int n);
    logic prev;
    wait_ev(kind);
    prev = blink_phase;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ev(kind, prev));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R8 phase", blink_phase, 0);
    check("R8 sel", blink_sel, 0);
    check("R8 frame_start", frame_start, 0);
    check("R8 irq", sof_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 frame_start after release", frame_start, 0);

    for (int i = 0; i < NV; i++) begin
      cfg_psc   = 4'(T_PSC[i]);
      cfg_ratio = 4'(T_RAT[i]);
      wait_ev(0); wait_ev(0);
      if (T_FPER[i] != 0) begin
        wait_ev(1); wait_ev(1);
      end
      measure(0, n);
      check($sformatf("R1 psc period psc=%0d", T_PSC[i]), n, T_PPER[i]);
      if (T_FPER[i] != 0) begin
        measure(1, n);
        check($sformatf("R2 frame period psc=%0d ratio=%0d", T_PSC[i], T_RAT[i]), n, T_FPER[i]);
      end
    end

    // R7: change the exponent just after a tick; old interval must complete
    cfg_psc = 4'd3;
    wait_ev(0); wait_ev(0); wait_ev(0);
    @(negedge clk);
    cfg_psc = 4'd1;
    n = 1;
    while (!psc_tick) begin
      @(negedge clk);
      n++;
    end
    check("R7 old period kept", n, 8);
    measure(0, n);
    check("R7 new period applied", n, 2);

    cfg_psc = 4'd0;
    cfg_ratio = 4'd0;
    wait_ev(0); wait_ev(1); wait_ev(1);

    // R3 blink rates, frame = 16 cycles
    cfg_blink_rate = 3'd0;
    wait_ev(2);
    measure(2, n);
    check("R3 blink half period rate 0", n, 64);
    cfg_blink_rate = 3'd1;
    wait_ev(2);
    measure(2, n);
    check("R3 blink half period rate 1", n, 128);
    cfg_blink_rate = 3'd7;
    wait_ev(2);
    measure(2, n);
    check("R3 blink half period rate 7", n, 8192);
    cfg_blink_rate = 3'd0;
    wait_ev(2); wait_ev(2);

    // R4 masks
    for (int m = 0; m < 4; m++) begin
      cfg_blink_mode = 2'(m);
      while (!blink_phase) @(negedge clk);
      check($sformatf("R4 sel mode %0d phase 1", m), blink_sel, (m == 0) ? 0 : (1 << (m - 1)));
      while (blink_phase) @(negedge clk);
      check($sformatf("R4 sel mode %0d phase 0", m), blink_sel, 0);
    end

    // R5/R6 interrupt
    sof_irq_en = 1'b0;
    wait_ev(1);
    @(negedge clk);
    check("R6 masked while disabled", sof_irq, 0);
    sof_irq_en = 1'b1;
    #1;
    check("R6 sticky flag shown once enabled", sof_irq, 1);
    sof_irq_clr = 1'b1;
    @(negedge clk);
    sof_irq_clr = 1'b0;
    check("R5 clear strobe", sof_irq, 0);
    wait_ev(1);
    check("R5 not yet set in strobe cycle", sof_irq, 0);
    @(negedge clk);
    check("R5 set visible next cycle", sof_irq, 1);
    sof_irq_clr = 1'b1;
    @(negedge clk);
    sof_irq_clr = 1'b0;
    check("R5 cleared again", sof_irq, 0);
    wait_ev(1);
    sof_irq_clr = 1'b1;
    @(negedge clk);
    sof_irq_clr = 1'b0;
    check("R5 set wins over clear", sof_irq, 1);
    sof_irq_clr = 1'b1;
    @(negedge clk);
    sof_irq_clr = 1'b0;
    check("R5 clear after collision", sof_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule